// File: doc/BRIEF.md
# Radio Receive Payload Fetch Sequencer

This block fetches one received packet from a packet radio transceiver when asked. It drives the radio through a byte-wide SPI master port. A shifter outside the block moves the bits. One `start` pulse runs a full sequence. The block reads the radio's status byte and checks whether a packet is waiting. If one is, it finds the packet length in one of two ways: from the static width register of the pipe that the status names, or from a dynamic-width query command. It clamps the length to the buffer size, reads the payload into a 32-byte output buffer, and writes the status register to clear the data-ready and max-retry flags.

If no packet is waiting and the status looks broken, the block does not read anything. A broken status is either all zeros, or it has bit 0 or bit 4 set. In that case the block flushes the radio's receive FIFO, clears the same flags, and reports a length of zero. When the sequence ends, a one-cycle `done` pulse marks the packet length, the data bytes and the captured status as valid.

Top module: `rx_fetch_seq`

## Requirements
- R1: `start` is accepted only while the block is idle; a `start` during a running fetch starts no extra frames. `done` is high for exactly one cycle per fetch, and `pkt_len`, `pkt_data` and `last_status` are valid in that cycle.
- R2: Every fetch begins with a one-byte frame carrying 0x07. The byte returned in that slot is captured as `last_status`.
- R3: With `dyn_mode` low and status bit 6 set, the block sends a two-byte frame {0x11 + pipe, 0x00}. Here pipe = status[3:1], and pipe 6 or 7 is replaced by 0. The second returned byte is the length.
- R4: With `dyn_mode` high and status bit 6 set, the length frame is {0x60, 0x00}, and the second returned byte is the length.
- R5: A length value above 32 is reduced to 32 before the payload read.
- R6: The payload frame is 0x61 followed by `pkt_len` bytes of 0x00. Returned byte k (k >= 1) lands in `pkt_data[8(k-1)+7 : 8(k-1)]`. Buffer bytes at or beyond `pkt_len` read as zero.
- R7: After the payload frame, the block sends the two-byte frame {0x27, 0x50}, and then `done` follows.
- R8: If status bit 6 is clear and the status is 0x00 or has bit 0 or bit 4 set, the block sends the one-byte frame {0xE2}, then {0x27, 0x50}, and finishes with `pkt_len` = 0.
- R9: If status bit 6 is clear and the status is not broken, no frame follows the status frame, and `pkt_len` = 0.
- R10: `spi_cs_n` stays low across all bytes of one frame and goes high for at least one cycle between frames. Only one byte is in flight at a time. `spi_go` is a one-cycle pulse that is issued only inside a frame.
- R11: After reset, `spi_cs_n` is high, and `spi_go`, `done` and `pkt_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one fetch |
| dyn_mode | input | 1 | 1: dynamic-width query, 0: per-pipe width register |
| spi_cs_n | output | 1 | Radio chip select, active low |
| spi_go | output | 1 | One-cycle request to shift out `spi_tx` |
| spi_tx | output | 8 | Byte to send |
| spi_done | input | 1 | Shifter finished the byte; `spi_rx` valid |
| spi_rx | input | 8 | Byte received during the last shift |
| done | output | 1 | One-cycle end-of-fetch pulse |
| pkt_len | output | 6 | Payload length, 0 to 32 |
| pkt_data | output | 256 | Payload, byte i at bits [8i+7:8i] |
| last_status | output | 8 | Status byte of the latest fetch |

## Verification
The bench targets five cases where a design could go wrong:
- **Pipe 7 in fixed mode.** A design that skips the pipe substitution addresses width register 0x18.
- **Width of 40.** A design that does not clamp overruns the buffer and sends 40 dummy bytes.
- **Width of 0.** The payload frame must shrink to the bare command byte. A design that gets this wrong sends extra bytes or stalls.
- **Broken status values 0x00, 0x01 and 0x10.** Each must trigger the flush-then-clear pair. A benign status such as 0x0E must end right after the status frame, so a flush there shows up as an unexpected frame.
- **Repeated `start` mid-fetch.** A second fetch started by mistake appears as extra frames after `done`.

After a long packet, a short one follows. If the buffer is not cleared at the start of each fetch, stale bytes appear past the new length.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    // Command bytes sent to the radio
    localparam logic [7:0] OP_REG_RD   = 8'h00;
    localparam logic [7:0] OP_REG_WR   = 8'h20;
    localparam logic [7:0] OP_PAY_RD   = 8'h61;
    localparam logic [7:0] OP_WID_QRY  = 8'h60;
    localparam logic [7:0] OP_RX_FLUSH = 8'hE2;
    localparam logic [7:0] REG_STAT    = 8'h07;
    localparam logic [7:0] REG_WID0    = 8'h11;
    localparam logic [7:0] CLR_FLAGS   = 8'h50;
    localparam int         NUM_PIPES   = 6;

    typedef enum logic [2:0] {
        S_IDLE, S_STAT, S_LEN, S_PAY, S_CLR, S_FLUSH, S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {E_IDLE, E_GO, E_WAIT, E_GAP} frm_state_t;

    // Limit a reported width to the buffer capacity
    function automatic int clamp_len(input logic [7:0] raw, input int lim);
        return (int'(raw) > lim) ? lim : int'(raw);
    endfunction
endpackage

// File: rtl/rxf_spi_frame.sv
// Frame engine: sends one command byte followed by `txn_extra` fill bytes
// under a single low chip-select span, one byte in flight at a time.
// Assumes the byte shifter answers every spi_go with exactly one spi_done.
module rxf_spi_frame #(
    parameter  int MAXB = 32,
    localparam int CW   = $clog2(MAXB + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          txn_start,
    input  logic [7:0]    txn_cmd,
    input  logic [7:0]    txn_fill,
    input  logic [CW-1:0] txn_extra,
    output logic          txn_done,
    output logic          rx_strobe,
    output logic [CW-1:0] rx_idx,
    output logic [7:0]    rx_byte,
    output logic          spi_cs_n,
    output logic          spi_go,
    output logic [7:0]    spi_tx,
    input  logic          spi_done,
    input  logic [7:0]    spi_rx
);
    import rxf_pkg::*;

    frm_state_t    st;
    logic [CW-1:0] idx, extra_q;
    logic [7:0]    cmd_q, fill_q;

    // Frame state walk: launch, wait for each byte, then one idle gap cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= E_IDLE;
            idx     <= '0;
            extra_q <= '0;
            cmd_q   <= '0;
            fill_q  <= '0;
        end else begin
            case (st)
                E_IDLE: if (txn_start) begin
                    cmd_q   <= txn_cmd;
                    fill_q  <= txn_fill;
                    extra_q <= txn_extra;
                    idx     <= '0;
                    st      <= E_GO;
                end
                E_GO:   st <= E_WAIT;
                E_WAIT: if (spi_done) begin
                    if (idx == extra_q) st <= E_GAP;
                    else begin
                        idx <= idx + 1'b1;
                        st  <= E_GO;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

    // Pin and strobe decode from the frame state
    always_comb begin
        spi_cs_n  = (st == E_IDLE) || (st == E_GAP);
        spi_go    = (st == E_GO);
        spi_tx    = (idx == '0) ? cmd_q : fill_q;
        rx_strobe = (st == E_WAIT) && spi_done;
        rx_idx    = idx;
        rx_byte   = spi_rx;
        txn_done  = (st == E_GAP);
    end

    assert_go_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |-> !spi_cs_n);
    assert_go_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |=> !spi_go);
    assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |=> spi_cs_n);
endmodule

// File: rtl/rxf_pkt_buf.sv
// Payload buffer: DEPTH byte registers, cleared as a whole, written one byte
// per strobe, presented as a flat vector with byte i at bits [8i+7:8i].
module rxf_pkt_buf #(
    parameter  int DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [7:0]         wdata,
    output logic [DEPTH*8-1:0] flat
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        logic [7:0] b;
        // One storage byte: zero on reset or clear, load on its address
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                        b <= '0;
            else if (we && waddr == AW'(g))           b <= wdata;
        end
        assign flat[g*8 +: 8] = b;
    end
endmodule

// File: rtl/rx_fetch_seq.sv
// Receive fetch sequencer: on start, reads radio status, obtains the payload
// length (fixed per-pipe register or dynamic query), reads the payload and
// clears flags; flushes the receive FIFO instead on a broken status.
// Assumes a byte-wide SPI shifter on the spi_go/spi_done handshake.
module rx_fetch_seq #(
    parameter  int MAX_LEN = 32,
    localparam int LW      = $clog2(MAX_LEN + 1),
    localparam int AW      = $clog2(MAX_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 dyn_mode,
    output logic                 spi_cs_n,
    output logic                 spi_go,
    output logic [7:0]           spi_tx,
    input  logic                 spi_done,
    input  logic [7:0]           spi_rx,
    output logic                 done,
    output logic [LW-1:0]        pkt_len,
    output logic [MAX_LEN*8-1:0] pkt_data,
    output logic [7:0]           last_status
);
    import rxf_pkg::*;

    seq_state_t    st;
    logic          launch, dyn_q;
    logic [7:0]    status_q;
    logic [LW-1:0] len_q;
    logic [7:0]    f_cmd, f_fill;
    logic [LW-1:0] f_extra;
    logic          f_done, rx_strobe;
    logic [LW-1:0] rx_idx;
    logic [7:0]    rx_byte;
    logic [2:0]    pipe_sel;
    logic          bad_stat, buf_clr, buf_we;
    logic [AW-1:0] buf_addr;

    // Pipe number from status, out-of-range pipes fall back to pipe 0
    always_comb begin
        pipe_sel = (int'(status_q[3:1]) >= NUM_PIPES) ? 3'd0 : status_q[3:1];
        bad_stat = (status_q == 8'h00) || status_q[0] || status_q[4];
    end

    // Frame parameters selected by the current phase
    always_comb begin
        f_cmd   = OP_REG_RD | REG_STAT;
        f_fill  = 8'h00;
        f_extra = '0;
        case (st)
            S_LEN: begin
                f_cmd   = dyn_q ? OP_WID_QRY : (OP_REG_RD | (REG_WID0 + {5'd0, pipe_sel}));
                f_extra = LW'(1);
            end
            S_PAY:   begin f_cmd = OP_PAY_RD; f_extra = len_q; end
            S_CLR:   begin f_cmd = OP_REG_WR | REG_STAT; f_fill = CLR_FLAGS; f_extra = LW'(1); end
            S_FLUSH: f_cmd = OP_RX_FLUSH;
            default: ;
        endcase
    end

    // Phase sequencing and capture of status and length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            launch   <= 1'b0;
            dyn_q    <= 1'b0;
            status_q <= '0;
            len_q    <= '0;
        end else begin
            launch <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    dyn_q  <= dyn_mode;
                    len_q  <= '0;
                    st     <= S_STAT;
                    launch <= 1'b1;
                end
                S_STAT: begin
                    if (rx_strobe) status_q <= rx_byte;
                    if (f_done) begin
                        if (status_q[6])   begin st <= S_LEN;   launch <= 1'b1; end
                        else if (bad_stat) begin st <= S_FLUSH; launch <= 1'b1; end
                        else               st <= S_DONE;
                    end
                end
                S_LEN: begin
                    if (rx_strobe && rx_idx == LW'(1))
                        len_q <= LW'(clamp_len(rx_byte, MAX_LEN));
                    if (f_done) begin st <= S_PAY; launch <= 1'b1; end
                end
                S_PAY:   if (f_done) begin st <= S_CLR; launch <= 1'b1; end
                S_FLUSH: if (f_done) begin st <= S_CLR; launch <= 1'b1; end
                S_CLR:   if (f_done) st <= S_DONE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Buffer control: clear on accepted start, write payload bytes 1..len
    always_comb begin
        buf_clr  = (st == S_IDLE) && start;
        buf_we   = (st == S_PAY) && rx_strobe && (rx_idx != '0);
        buf_addr = AW'(rx_idx - LW'(1));
    end

    rxf_spi_frame #(.MAXB(MAX_LEN)) i_frame (
        .clk(clk), .rst_n(rst_n),
        .txn_start(launch), .txn_cmd(f_cmd), .txn_fill(f_fill), .txn_extra(f_extra),
        .txn_done(f_done), .rx_strobe(rx_strobe), .rx_idx(rx_idx), .rx_byte(rx_byte),
        .spi_cs_n(spi_cs_n), .spi_go(spi_go), .spi_tx(spi_tx),
        .spi_done(spi_done), .spi_rx(spi_rx)
    );

    rxf_pkt_buf #(.DEPTH(MAX_LEN)) i_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .waddr(buf_addr), .wdata(rx_byte), .flat(pkt_data)
    );

    assign done        = (st == S_DONE);
    assign pkt_len     = len_q;
    assign last_status = status_q;

    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_len_clamped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(pkt_len) <= MAX_LEN));
    assert_nodata_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !last_status[6]) |-> (pkt_len == '0));
    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spi_cs_n);
endmodule

// File: tb/test_rx_fetch_seq.sv
module test_rx_fetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dyn_mode = 1'b0;
    logic         spi_cs_n, spi_go, done;
    logic [7:0]   spi_tx, last_status;
    logic         spi_done = 1'b0;
    logic [7:0]   spi_rx = 8'h00;
    logic [5:0]   pkt_len;
    logic [255:0] pkt_data;

    int n_cmp = 0, n_bad = 0;

    // Radio model settings
    logic [7:0] r_status;
    int         r_dyn_w;
    int         r_fix_w [8];
    logic [7:0] r_pay   [64];

    // Expected frame stream
    int exp_bytes[$];
    int exp_flen[$];

    rx_fetch_seq i_rx_fetch_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dyn_mode(dyn_mode),
        .spi_cs_n(spi_cs_n), .spi_go(spi_go), .spi_tx(spi_tx),
        .spi_done(spi_done), .spi_rx(spi_rx), .done(done),
        .pkt_len(pkt_len), .pkt_data(pkt_data), .last_status(last_status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Radio model and per-clock frame monitor, sampled on the falling edge
    int         cnt = 0, frm_idx = 0, frm_cnt = 0;
    logic [7:0] frm_cmd = 0, resp = 0;
    logic       prev_cs = 1'b1;
    always @(negedge clk) begin
        spi_done = 1'b0;
        if (rst_n) begin
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin spi_done = 1'b1; spi_rx = resp; end
            end
            if (spi_cs_n) frm_idx = 0;
            if (spi_go) begin
                if (frm_idx == 0) begin
                    frm_cmd = spi_tx;
                    resp = r_status;
                end else if (frm_cmd == 8'h60) resp = 8'(r_dyn_w);
                else if (frm_cmd >= 8'h11 && frm_cmd <= 8'h18) resp = 8'(r_fix_w[frm_cmd - 8'h11]);
                else if (frm_cmd == 8'h61) resp = r_pay[frm_idx - 1];
                else resp = 8'h00;
                frm_idx++;
                frm_cnt++;
                cnt = LAT;
                if (exp_bytes.size() == 0)
                    check(1'b0, "R1", "unexpected byte", spi_tx, 0);
                else begin
                    int e;
                    e = exp_bytes.pop_front();
                    check(spi_tx == 8'(e), "R10", "frame byte", spi_tx, e);
                end
            end
            if (spi_cs_n && !prev_cs) begin
                if (exp_flen.size() == 0)
                    check(1'b0, "R1", "unexpected frame", frm_cnt, 0);
                else begin
                    int e;
                    e = exp_flen.pop_front();
                    check(frm_cnt == e, "R10", "frame length", frm_cnt, e);
                end
                frm_cnt = 0;
            end
            prev_cs = spi_cs_n;
        end
    end

    task automatic push_frame(input int b0, input int nfill, input int fill);
        exp_bytes.push_back(b0);
        for (int i = 0; i < nfill; i++) exp_bytes.push_back(fill);
        exp_flen.push_back(nfill + 1);
    endtask

    // Build expectations, run one fetch, compare outputs at done
    task automatic fetch(input logic [7:0] st, input bit dyn, input string req,
                         input bit poke_busy);
        int L, p, w, tmo;
        logic [255:0] ed;
        L = 0;
        ed = '0;
        r_status = st;
        push_frame(8'h07, 0, 0);
        if (st[6]) begin
            if (dyn) begin
                push_frame(8'h60, 1, 0);
                w = r_dyn_w;
            end else begin
                p = int'(st[3:1]);
                if (p > 5) p = 0;
                push_frame(8'h11 + p, 1, 0);
                w = r_fix_w[p];
            end
            L = (w > 32) ? 32 : w;
            push_frame(8'h61, L, 0);
            push_frame(8'h27, 1, 8'h50);
            for (int i = 0; i < L; i++) ed[i*8 +: 8] = r_pay[i];
        end else if (st == 8'h00 || st[0] || st[4]) begin
            push_frame(8'hE2, 0, 0);
            push_frame(8'h27, 1, 8'h50);
        end
        @(negedge clk);
        dyn_mode = dyn;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dyn_mode = ~dyn;
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        tmo = 0;
        while (!done && tmo < 3000) begin @(negedge clk); tmo++; end
        check(done == 1'b1, "R1", {req, " done seen"}, done, 1);
        check(int'(pkt_len) == L, req, "pkt_len", pkt_len, L);
        check(last_status == st, "R2", "last_status", last_status, st);
        check(pkt_data == ed, req, "pkt_data", pkt_data[63:0], ed[63:0]);
        @(negedge clk);
        check(done == 1'b0, "R1", "done pulse width", done, 0);
        repeat (20) @(negedge clk);
        check(exp_bytes.size() == 0 && exp_flen.size() == 0, req, "frames left unsent",
              exp_bytes.size(), 0);
        exp_bytes.delete();
        exp_flen.delete();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) r_pay[i] = 8'(8'h3C + i * 29);
        for (int i = 0; i < 8; i++) r_fix_w[i] = 40 + i;
        r_fix_w[0] = 5;
        r_fix_w[3] = 12;
        r_dyn_w = 0;
        r_status = 8'h0E;
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_go == 1'b0 && done == 1'b0 && pkt_len == 0,
              "R11", "reset state", {spi_cs_n, spi_go, done}, 3'b100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        fetch(8'h40, 1'b0, "R3", 1'b0);          // pipe 0, width 5
        fetch(8'h46, 1'b0, "R3", 1'b0);          // pipe 3, width 12
        fetch(8'h4E, 1'b0, "R3", 1'b0);          // pipe 7 maps to pipe 0
        r_fix_w[1] = 45;
        fetch(8'h42, 1'b0, "R5", 1'b0);          // fixed width clamped
        r_dyn_w = 32;
        fetch(8'h40, 1'b1, "R4", 1'b0);          // dynamic, full buffer
        r_dyn_w = 3;
        fetch(8'h40, 1'b1, "R6", 1'b0);          // short after long: stale bytes zero
        r_dyn_w = 40;
        fetch(8'h40, 1'b1, "R5", 1'b0);          // dynamic clamp
        r_dyn_w = 0;
        fetch(8'h40, 1'b1, "R6", 1'b0);          // zero-length payload
        fetch(8'h00, 1'b0, "R8", 1'b0);          // zero status flush
        fetch(8'h01, 1'b1, "R8", 1'b0);          // bit 0 flush
        fetch(8'h10, 1'b0, "R8", 1'b0);          // bit 4 flush
        fetch(8'h0E, 1'b0, "R9", 1'b0);          // benign empty status
        r_dyn_w = 7;
        fetch(8'h40, 1'b1, "R7", 1'b1);          // start while busy ignored (R1)
        fetch(8'h44, 1'b0, "R3", 1'b0);          // back to back, pipe 2

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(negedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule